// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between a MAC's transmit interface and the line-side transmit path. It watches the transmit-enable strobe. When a station keeps that strobe high for longer than any legal frame, which usually means a fault, the block cuts the frame off from the line. It counts the consecutive clock cycles in which enable is high and compares the count with a timeout given in clock cycles. The default timeout of 1,125,000 cycles equals 45 ms at a 25 MHz transmit clock.

Once the timeout has run out, the line-side enable, error and data outputs are held at zero and an abort indication is raised. Both stay in force until the MAC drops its enable. A sticky jabber flag records the event for software. A status-read strobe clears the flag, but only when the abort is no longer in force at the time of the read.

Every output is registered, so the line side follows the MAC side one clock later.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset, or when reset is asserted at any time, `line_en`, `line_er`, `line_d`, `jab_active` and `jab_flag` are all zero one clock later.
- R2: While no abort is in force, `line_en`, `line_er` and `line_d` equal `tx_en`, `tx_er` and `txd` from the previous clock.
- R3: A run of up to TIMEOUT consecutive cycles with `tx_en` high reaches the line in full. For input cycle TIMEOUT+1 of the run, `line_en`, `line_er` and `line_d` are zero and `jab_active` is 1.
- R4: The cycle count saturates and never wraps. However long `tx_en` stays high after the timeout, the line outputs stay zero and `jab_active` stays 1.
- R5: One input cycle with `tx_en` low ends the abort: `jab_active` is 0 for that cycle's output, and a new frame afterwards passes to the line.
- R6: The count goes back to zero on every cycle with `tx_en` low. Two runs of TIMEOUT cycles separated by a single low cycle both pass in full.
- R7: `jab_flag` rises in the same output cycle as `jab_active`. It stays high after `jab_active` falls, until it is read.
- R8: A `stat_rd` pulse sampled while `jab_active` is 1 leaves `jab_flag` at 1.
- R9: A `stat_rd` pulse sampled while `jab_active` is 0 clears `jab_flag` on the next output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | DW | Transmit data from the MAC |
| stat_rd | input | 1 | Status-read strobe; clears the jabber flag when no abort is in force |
| line_en | output | 1 | Gated transmit enable toward the line |
| line_er | output | 1 | Gated transmit error toward the line |
| line_d | output | DW | Gated transmit data toward the line |
| jab_active | output | 1 | Abort in force (jabber condition present) |
| jab_flag | output | 1 | Sticky jabber status bit |

## Verification
The bench aims at the exact cycle where the cut falls. A design that is off by one would either clip a legal frame of exactly TIMEOUT cycles or let one extra cycle reach the line. Two full-length frames separated by a single idle cycle show whether the count restarts; a design that accumulated across frames would cut the second one. A long hold of several timeouts exposes a counter that wraps, which would let data leak back onto the line. A read issued while the abort is still in force checks that the flag is not dropped early, and a read just after release checks that it does clear.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HELD = 2'd2
  } jab_phase_e;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/jab_timer.sv
module jab_timer
  import jab_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1125000,
  parameter int unsigned CW      = cnt_bits(TIMEOUT)
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  output logic blocked
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;
  jab_phase_e    phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
    end else if (!tx_en) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE, PH_RUN: begin
          if (cnt_q == LIMIT - 1'b1) begin
            cnt_q   <= LIMIT;
            phase_q <= PH_HELD;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            phase_q <= PH_RUN;
          end
        end
        default: begin
          cnt_q   <= LIMIT;
          phase_q <= PH_HELD;
        end
      endcase
    end
  end

  assign blocked = tx_en && (phase_q == PH_HELD);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (cnt_q == '0));

  // R4
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && cnt_q == LIMIT) |=> (cnt_q == LIMIT || cnt_q == '0));
endmodule

// File: rtl/jab_gate.sv
module jab_gate #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blocked,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic [DW-1:0] txd,
  output logic          line_en,
  output logic          line_er,
  output logic [DW-1:0] line_d,
  output logic          jab_active
);
  always_ff @(posedge clk) begin
    if (rst || blocked) begin
      line_en <= 1'b0;
      line_er <= 1'b0;
      line_d  <= '0;
    end else begin
      line_en <= tx_en;
      line_er <= tx_er;
      line_d  <= txd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) jab_active <= 1'b0;
    else     jab_active <= blocked;
  end

  // R3
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    jab_active |-> (!line_en && !line_er && line_d == '0));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!jab_active && !line_en));
endmodule

// File: rtl/jab_status.sv
module jab_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic active_i,
  input  logic stat_rd,
  output logic jab_flag
);
  logic clear_ok;
  assign clear_ok = stat_rd && !active_i;

  always_ff @(posedge clk) begin
    if (rst)           jab_flag <= 1'b0;
    else if (set_i)    jab_flag <= 1'b1;
    else if (clear_ok) jab_flag <= 1'b0;
  end

  // R7
  flag_covers_chk: assert property (@(posedge clk) disable iff (rst)
    active_i |-> jab_flag);

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && active_i) |=> jab_flag);
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int unsigned TIMEOUT = 1125000,
  parameter int unsigned DW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic [DW-1:0] txd,
  input  logic          stat_rd,
  output logic          line_en,
  output logic          line_er,
  output logic [DW-1:0] line_d,
  output logic          jab_active,
  output logic          jab_flag
);
  logic blocked;

  jab_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .blocked (blocked)
  );

  jab_gate #(.DW(DW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .blocked    (blocked),
    .tx_en      (tx_en),
    .tx_er      (tx_er),
    .txd        (txd),
    .line_en    (line_en),
    .line_er    (line_er),
    .line_d     (line_d),
    .jab_active (jab_active)
  );

  jab_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (blocked),
    .active_i (jab_active),
    .stat_rd  (stat_rd),
    .jab_flag (jab_flag)
  );

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!blocked && !$past(rst)) |=> (line_en == $past(tx_en) && line_d == $past(txd)));
endmodule

// File: tb/tx_jabber_guard_bench.sv
module tx_jabber_guard_bench;
  localparam int unsigned T  = 6;
  localparam int unsigned DW = 4;

  logic clk = 1'b0;
  logic rst, tx_en, tx_er, stat_rd;
  logic [DW-1:0] txd;
  logic line_en, line_er, jab_active, jab_flag;
  logic [DW-1:0] line_d;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tx_jabber_guard #(.TIMEOUT(T), .DW(DW)) u_tx_jabber_guard (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .stat_rd(stat_rd), .line_en(line_en), .line_er(line_er),
    .line_d(line_d), .jab_active(jab_active), .jab_flag(jab_flag)
  );

  // row: req[18:15] en er d[3:0] rd | exp en er d[3:0] act flag
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 1'b1,1'b0,4'h1,1'b0, 1'b1,1'b0,4'h1,1'b0,1'b0}, // R2
    {4'd2, 1'b1,1'b1,4'h2,1'b0, 1'b1,1'b1,4'h2,1'b0,1'b0}, // R2
    {4'd2, 1'b1,1'b0,4'h3,1'b0, 1'b1,1'b0,4'h3,1'b0,1'b0}, // R2
    {4'd2, 1'b0,1'b0,4'h0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0}, // R2
    {4'd3, 1'b1,1'b0,4'h4,1'b0, 1'b1,1'b0,4'h4,1'b0,1'b0}, // R3 run 1
    {4'd3, 1'b1,1'b0,4'h5,1'b0, 1'b1,1'b0,4'h5,1'b0,1'b0}, // R3
    {4'd3, 1'b1,1'b0,4'h6,1'b0, 1'b1,1'b0,4'h6,1'b0,1'b0}, // R3
    {4'd3, 1'b1,1'b0,4'h7,1'b0, 1'b1,1'b0,4'h7,1'b0,1'b0}, // R3
    {4'd3, 1'b1,1'b0,4'h8,1'b0, 1'b1,1'b0,4'h8,1'b0,1'b0}, // R3
    {4'd3, 1'b1,1'b1,4'h9,1'b0, 1'b1,1'b1,4'h9,1'b0,1'b0}, // R3 cycle T
    {4'd6, 1'b0,1'b0,4'h0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0}, // R6 one idle
    {4'd6, 1'b1,1'b0,4'hA,1'b0, 1'b1,1'b0,4'hA,1'b0,1'b0}, // R6 run 2
    {4'd6, 1'b1,1'b0,4'hB,1'b0, 1'b1,1'b0,4'hB,1'b0,1'b0}, // R6
    {4'd6, 1'b1,1'b0,4'hC,1'b0, 1'b1,1'b0,4'hC,1'b0,1'b0}, // R6
    {4'd6, 1'b1,1'b0,4'hD,1'b0, 1'b1,1'b0,4'hD,1'b0,1'b0}, // R6
    {4'd6, 1'b1,1'b0,4'hE,1'b0, 1'b1,1'b0,4'hE,1'b0,1'b0}, // R6
    {4'd6, 1'b1,1'b0,4'hF,1'b0, 1'b1,1'b0,4'hF,1'b0,1'b0}, // R6 cycle T
    {4'd3, 1'b1,1'b1,4'hA,1'b0, 1'b0,1'b0,4'h0,1'b1,1'b1}, // R3 cut, R7 flag
    {4'd8, 1'b1,1'b0,4'hB,1'b1, 1'b0,1'b0,4'h0,1'b1,1'b1}, // R8 read held
    {4'd4, 1'b1,1'b0,4'hC,1'b0, 1'b0,1'b0,4'h0,1'b1,1'b1}, // R4
    {4'd7, 1'b0,1'b0,4'h0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b1}, // R7 sticky, R5
    {4'd9, 1'b0,1'b0,4'h0,1'b1, 1'b0,1'b0,4'h0,1'b0,1'b0}, // R9 clear
    {4'd5, 1'b1,1'b0,4'h5,1'b0, 1'b1,1'b0,4'h5,1'b0,1'b0}  // R5 new frame
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {line_en, line_er, line_d, jab_active, jab_flag};
  endfunction

  task automatic step(input logic en, input logic er, input logic [3:0] d, input logic rd);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; stat_rd = rd;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; tx_en = 1'b0; tx_er = 1'b0; txd = '0; stat_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", outs(), 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step(v[14], v[13], v[12:9], v[8]);
      check($sformatf("R%0d row %0d", v[18:15], i), outs(), v[7:0]);
    end

    // R4: long hold, far beyond the timeout
    step(1'b0, 1'b0, 4'h0, 1'b0);
    step(1'b0, 1'b0, 4'h0, 1'b1);
    for (int k = 1; k <= 5 * T; k++) begin
      step(1'b1, 1'b1, 4'h6, 1'b0);
      if (k <= T) check("R4 pre-timeout", outs(), {1'b1, 1'b1, 4'h6, 1'b0, 1'b0});
      else        check("R4 held", outs(), {1'b0, 1'b0, 4'h0, 1'b1, 1'b1});
    end
    // R1: reset during an abort clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset mid-abort", outs(), 8'h00);
    @(negedge clk);
    rst = 1'b0; tx_en = 1'b0;
    step(1'b1, 1'b0, 4'h3, 1'b0);
    check("R2 after reset", outs(), {1'b1, 1'b0, 4'h3, 1'b0, 1'b0});
    step(1'b0, 1'b0, 4'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule